// File: doc/BRIEF.md
# Prefix-Addressed Synthesizer Register Loader

This block sits behind a serial-bus deserializer in a frequency synthesizer. It takes whole 8-bit control bytes, each with a valid strobe, and a separate strobe that marks the end of a bus transfer. The two top bits of every byte select the fields that the byte writes. A byte can write the upper main-counter bits together with the loop control bits, the lower main-counter bits, the swallow counter, or the switch, reference and test group. The bytes carry their own addresses, so a transfer may rewrite only the swallow counter, or only the two counter bytes, and every other field keeps its value.

Incoming bytes update a shadow copy of every field. The outputs that drive the divider, charge pump, loop filter and mode logic change only when the transfer ends, so they never show a half-written divider value. When the 25 kHz-style reference select is committed, the block forces the committed swallow bit 5 to zero. The shadow still holds the value that was written.

Top module: `synth_reg_loader`

## Requirements
- R1: While reset is asserted, and right after it, every output is zero. Test mode is off.
- R2: A valid byte with top bits 01 writes its bits 5..0 to main_div[7], main_div[6], lf_sel, cp_cur1, sw_dir and band_fm, in that order.
- R3: A valid byte with top bits 10 writes its bits 5..0 to main_div[5:0].
- R4: A valid byte with top bits 11 writes its bits 5..0 to swallow[5:0].
- R5: A valid byte with top bits 00 writes bits 5..3 to test_mode[2:0], bit 2 to sw_out, bit 1 to cp_cur2 and bit 0 to ref_sel. A byte of the form 00000xxx therefore also clears test mode.
- R6: Outputs change only at a clock edge where xfer_end is high. Bytes that arrive earlier are invisible until that edge.
- R7: When a transfer ends, a field that no byte of that transfer addressed keeps its previous value, so partial transfers work.
- R8: A valid byte that arrives in the same cycle as xfer_end is included in that commit.
- R9: When the committed ref_sel is 1, the committed swallow[5] is 0. The written swallow bit 5 is kept and appears again at a later commit with ref_sel 0.
- R10: When byte_vld is low, byte_in has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | byte_in holds a valid byte this cycle |
| byte_in | input | 8 | Deserialized control byte |
| xfer_end | input | 1 | End of transfer; commit the shadow fields |
| main_div | output | 8 | Main (program) counter value |
| swallow | output | 6 | Swallow counter value |
| lf_sel | output | 1 | Loop filter select |
| cp_cur1 | output | 1 | Charge-pump current bit 1 |
| cp_cur2 | output | 1 | Charge-pump current bit 2 |
| band_fm | output | 1 | AM/FM mode select |
| sw_dir | output | 1 | Switch-mode / direction bit |
| sw_out | output | 1 | Switch output pin level |
| ref_sel | output | 1 | Reference frequency select |
| test_mode | output | 3 | Test bits |

## Verification
A byte write and a commit can happen in the same cycle. In that case the byte must reach the outputs at once, not one transfer later. The bench raises byte_vld and xfer_end together, both in directed cases and in random ones where end strobes land on random bytes. It then compares every output, one cycle later, with a reference model that applies the byte before it commits. The same cycle can also commit a new ref_sel and new swallow bits together. The clamp of swallow bit 5 is judged against the ref_sel value committed in that same cycle.

// File: rtl/synth_reg_loader.sv
module synth_reg_loader (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       xfer_end,
  output logic [7:0] main_div,
  output logic [5:0] swallow,
  output logic       lf_sel,
  output logic       cp_cur1,
  output logic       cp_cur2,
  output logic       band_fm,
  output logic       sw_dir,
  output logic       sw_out,
  output logic       ref_sel,
  output logic [2:0] test_mode
);

  logic [7:0] sh_pc, nx_pc;
  logic [5:0] sh_sc, nx_sc;
  logic [3:0] sh_ctl, nx_ctl;   // lf, cur1, dir, fm
  logic [5:0] sh_aux, nx_aux;   // test[2:0], sw_out, cur2, ref

  wire [1:0] pfx = byte_in[7:6];

  always_comb begin
    nx_pc  = sh_pc;
    nx_sc  = sh_sc;
    nx_ctl = sh_ctl;
    nx_aux = sh_aux;
    if (byte_vld) begin
      case (pfx)
        2'b01: begin
          nx_pc[7:6] = byte_in[5:4];
          nx_ctl     = byte_in[3:0];
        end
        2'b10: nx_pc[5:0] = byte_in[5:0];
        2'b11: nx_sc      = byte_in[5:0];
        default: nx_aux   = byte_in[5:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_pc <= '0; sh_sc <= '0; sh_ctl <= '0; sh_aux <= '0;
      main_div <= '0; swallow <= '0;
      {lf_sel, cp_cur1, sw_dir, band_fm} <= '0;
      {test_mode, sw_out, cp_cur2, ref_sel} <= '0;
    end else begin
      sh_pc <= nx_pc; sh_sc <= nx_sc; sh_ctl <= nx_ctl; sh_aux <= nx_aux;
      if (xfer_end) begin
        main_div <= nx_pc;
        swallow  <= {nx_sc[5] & ~nx_aux[0], nx_sc[4:0]};
        {lf_sel, cp_cur1, sw_dir, band_fm} <= nx_ctl;
        {test_mode, sw_out, cp_cur2, ref_sel} <= nx_aux;
      end
    end
  end

endmodule

module synth_reg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_vld,
  input logic [7:0] byte_in,
  input logic       xfer_end,
  input logic [7:0] main_div,
  input logic [5:0] swallow,
  input logic       ref_sel,
  input logic [2:0] test_mode
);
  // R9
  ref_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_sel |-> !swallow[5]);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_end |=> $stable({main_div, swallow, ref_sel, test_mode}));

  // R8
  swallow_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && xfer_end && byte_in[7:6] == 2'b11) |=> swallow[4:0] == $past(byte_in[4:0]));

  // R3
  low_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && xfer_end && byte_in[7:6] == 2'b10) |=> main_div[5:0] == $past(byte_in[5:0]));

  // R5
  test_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && xfer_end && byte_in[7:3] == 5'b00000) |=> test_mode == 3'b000);
endmodule

bind synth_reg_loader synth_reg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
  .xfer_end(xfer_end), .main_div(main_div), .swallow(swallow),
  .ref_sel(ref_sel), .test_mode(test_mode)
);

// File: tb/tb_synth_reg_loader.sv
module tb_synth_reg_loader;
  logic clk = 0, rst_n = 0, byte_vld = 0, xfer_end = 0;
  logic [7:0] byte_in = 0;
  logic [7:0] main_div;
  logic [5:0] swallow;
  logic lf_sel, cp_cur1, cp_cur2, band_fm, sw_dir, sw_out, ref_sel;
  logic [2:0] test_mode;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  synth_reg_loader dut (.*);

  logic [7:0] m_pc = 0;
  logic [5:0] m_sc = 0;
  logic [3:0] m_ctl = 0;
  logic [5:0] m_aux = 0;
  logic [23:0] m_act = 0;

  function automatic logic [23:0] commit_val();
    return {m_pc, m_sc[5] & ~m_aux[0], m_sc[4:0], m_ctl, m_aux};
  endfunction

  wire [23:0] dut_vec = {main_div, swallow, lf_sel, cp_cur1, sw_dir, band_fm,
                         test_mode, sw_out, cp_cur2, ref_sel};

  task automatic check(string tag, logic [23:0] exp);
    checks++;
    if (dut_vec !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, dut_vec, exp);
    end
  endtask

  task automatic step(logic v, logic [7:0] b, logic e, string tag);
    byte_vld = v; byte_in = b; xfer_end = e;
    if (v) case (b[7:6])
      2'b01: begin m_pc[7:6] = b[5:4]; m_ctl = b[3:0]; end
      2'b10: m_pc[5:0] = b[5:0];
      2'b11: m_sc = b[5:0];
      default: m_aux = b[5:0];
    endcase
    if (e) m_act = commit_val();
    @(negedge clk);
    check(tag, m_act);
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    check("R1 in reset", 24'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 24'h0);
    // R2, R3, R4 full transfer; commit separate
    step(1, 8'b01_10_1101, 0, "R6 pending 01");
    step(1, 8'b10_101010, 0, "R6 pending 10");
    step(1, 8'b11_010101, 0, "R6 pending 11");
    step(0, 8'h00, 1, "R2 R3 R4 commit");
    if (main_div !== 8'hAA || lf_sel !== 1'b1 || band_fm !== 1'b1) begin
      errors++; $display("FAIL R2: actual=%h expected=aa", main_div);
    end
    checks++;
    // R5 test bits then cleared by 00000 byte
    step(1, 8'b00_101_110, 1, "R5 test set");
    if (test_mode !== 3'b101) begin errors++; $display("FAIL R5: actual=%b expected=101", test_mode); end
    checks++;
    step(1, 8'b00000_010, 1, "R5 test clear");
    // R7 partial transfer: only swallow
    step(1, 8'b11_000111, 1, "R7 swallow only");
    // R8 byte with end
    step(1, 8'b10_000011, 1, "R8 same cycle");
    // R9 clamp
    step(1, 8'b11_111111, 0, "R9 pending");
    step(1, 8'b00000_001, 1, "R9 clamp");
    if (swallow !== 6'h1F) begin errors++; $display("FAIL R9: actual=%h expected=1f", swallow); end
    checks++;
    step(1, 8'b00000_000, 1, "R9 release");
    if (swallow !== 6'h3F) begin errors++; $display("FAIL R9: actual=%h expected=3f", swallow); end
    checks++;
    // R10 ignored byte
    step(0, 8'hFF, 1, "R10 ignored ff");
    step(0, 8'h40, 1, "R10 ignored 40");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic v, e;
      logic [7:0] b;
      v = ($urandom % 4) != 0;
      e = ($urandom % 4) == 0;
      b = $urandom;
      if (($urandom % 3) == 0) b[7:3] = 5'b00000;
      step(v, b, e, "R6 R7 R8 R9 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule